// File: doc/BRIEF.md
# SDR SDRAM Command Sequencer

This block sits between a simple request port and one rank of single-data-rate SDRAM. It serves one read or one write of a 64-bit word at a time. Each request has a write flag, a 23-bit word address, data and byte enables. The block turns the request into a bank-activate, a column command and a single-bank precharge. It drives the active-low command pins, bank and address lines, clock enable, byte masks and the outgoing data lane. Read data returns on a one-cycle valid pulse.

After reset the block runs a power-up sequence before it accepts any work. The sequence is a wait, a precharge of all banks, two auto refreshes and a mode register write. An external scheduler raises a refresh request at any time. The sequencer serves that request at the next idle point and acknowledges it in the cycle the refresh command goes out. Every spacing between commands is counted in clocks and set by parameters, and the CAS latency may be 2 or 3.

Every row is closed again before the next request is taken, so no bank is ever left open between requests. A gap of N clocks in this brief means that the later command appears on the pins at least N rising edges after the earlier one.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is high, the command is NOP, clock enable is low, `req_ready`, `rd_valid` and `ref_ack` are low, and the data lane is not driven. From the first clock edge after reset, clock enable stays high.
- R2: After reset the controller waits `INIT_CYC` rising edges and issues a precharge with A10 high. It then issues two auto refreshes, the first `T_RP` after the precharge and the second `T_RC` after the first. A mode register set follows `T_RC` later. Its address is CAS latency in A[6:4], sequential burst type (A3=0), burst length 1 (A[2:0]=000) and all other bits 0. No activate, read or write command comes before that mode register set.
- R3: The pin encodings on {cs_n, ras_n, cas_n, we_n} are: mode set 0000, refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. No other code is driven.
- R4: The request address splits into column = addr[8:0], bank = addr[10:9] and row = addr[22:11]. Activate carries the bank and the row. Read and write carry the same bank, the column in A[8:0] and A10 low (no auto-precharge). The closing precharge carries the same bank with A10 low.
- R5: Minimum gaps are: activate to read/write `T_RCD`, activate to precharge `T_RAS`, precharge to activate or refresh `T_RP`, and activate to activate `T_RC`. Refresh to refresh, activate or mode set is also `T_RC`, and mode set to any command is `T_MRD`.
- R6: In a write command's cycle, `sd_dq_oe` is high, `sd_dq_out` carries the write data and `sd_dqm` is the bitwise inverse of the byte enables. In every other cycle, `sd_dq_oe` and `sd_dqm` are 0.
- R7: The precharge that follows a write comes at least `T_WR` clocks after the write command.
- R8: Read data is sampled from `sd_dq_in` exactly `CAS_LAT` rising edges after the edge at which the device registers the read command. It is presented on `rd_data` with a one-cycle `rd_valid` on the next cycle. The precharge after a read comes no earlier than `CAS_LAT` clocks after the read.
- R9: While `ref_req` is high, `req_ready` is low. A refresh is issued at the first idle point, with `ref_ack` high in the same cycle as the refresh command. If a refresh request and a new request are pending together, the refresh goes first.
- R10: The controller serves one request at a time. An accepted request (`req_valid` and `req_ready` at a rising edge) puts an activate on the pins the next cycle. `req_ready` stays low until that access's precharge gap has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {row, bank, column} |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for the write, bit n covers byte n |
| rd_valid | output | 1 | One-cycle pulse with returned read data |
| rd_data | output | 64 | Returned read data |
| ref_req | input | 1 | Refresh wanted, level held until acknowledged |
| ref_ack | output | 1 | High in the cycle the refresh command is driven |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Multiplexed row / column / mode address |
| sd_dqm | output | 8 | Byte masks, high = masked |
| sd_dq_out | output | 64 | Outgoing data lane |
| sd_dq_oe | output | 1 | Drive enable for the outgoing lane |
| sd_dq_in | input | 64 | Incoming data lane |

## Verification
A refresh request and a fresh access request can both be pending in the same idle cycle. The bench raises `ref_req` and `req_valid` on the same clock. It then checks that the refresh command and its acknowledge come first and that no activate is decided while the refresh request was still high. It also checks that the activate respects the refresh-to-activate gap. The second collision is a read's data return against the closing precharge. The bench memory schedules the read data for its exact CAS-latency cycle and drives junk on the data lane in every other cycle. Any shift in the capture point then shows up as wrong data, and the precharge spacing is measured against the read.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int BANK_W = 2;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int DATA_W = 64;
    localparam int MASK_W = DATA_W / 8;
    localparam int AP_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    // each waiting state names the command it issues once its counter is 0
    typedef enum logic [2:0] {
        ST_IPRE,
        ST_IREF1,
        ST_IREF2,
        ST_IMRS,
        ST_IDLE,
        ST_RW,
        ST_PRE
    } seq_st_e;

    typedef struct packed {
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
        logic [MASK_W-1:0] be;
    } sd_req_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic sd_req_t split_req(input logic wr,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d,
                                          input logic [MASK_W-1:0] be);
        sd_req_t r;
        r.wr   = wr;
        r.col  = a[COL_W-1:0];
        r.bank = a[COL_W+BANK_W-1:COL_W];
        r.row  = a[ADDR_W-1:COL_W+BANK_W];
        r.data = d;
        r.be   = be;
        return r;
    endfunction

    // burst length 1, sequential, burst writes, latency in [6:4]
    function automatic logic [ROW_W-1:0] mode_word(input int cl);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[6:4] = 3'(cl);
        return m;
    endfunction

endpackage

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture
    import sdram_seq_pkg::*;
#(
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issued,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // bit k set: read registered by the device k+1 edges ago
    logic [CAS_LAT-1:0] flight;

    always_ff @(posedge clk) begin
        if (rst) begin
            flight   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            flight   <= {flight[CAS_LAT-2:0], rd_issued};
            rd_valid <= flight[CAS_LAT-1];
            if (flight[CAS_LAT-1])
                rd_data <= dq_in;
        end
    end

    // data returns a fixed latency after the read left the pins
    p_capture_latency_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_issued, CAS_LAT + 1));

    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int CAS_LAT  = 2,
    parameter int T_RCD    = 2,
    parameter int T_RP     = 2,
    parameter int T_RAS    = 5,
    parameter int T_RC     = 7,
    parameter int T_WR     = 2,
    parameter int T_MRD    = 2,
    parameter int INIT_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_be,
    input  logic              ref_req,
    output logic              ref_ack,
    output logic              cke,
    output sd_cmd_e           cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ROW_W-1:0]  addr,
    output logic [MASK_W-1:0] dqm,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    // column command to precharge, per direction
    localparam int G_RD  = imax(T_RAS - T_RCD, CAS_LAT);
    localparam int G_WR  = imax(T_RAS - T_RCD, T_WR);
    // precharge to next idle command, keeping the row cycle
    localparam int GI_RD = imax(T_RP, T_RC - T_RCD - G_RD);
    localparam int GI_WR = imax(T_RP, T_RC - T_RCD - G_WR);
    localparam int CNT_MAX = imax(INIT_CYC, T_RC + T_RAS + CAS_LAT + T_WR + T_MRD);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1) << AP_BIT;

    seq_st_e          st;
    logic [CNT_W-1:0] cnt;
    sd_req_t          cur;

    assign req_ready = (st == ST_IDLE) && (cnt == '0) && !ref_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IPRE;
            cnt     <= CNT_W'(INIT_CYC - 1);
            cur     <= '0;
            cmd     <= CMD_NOP;
            cke     <= 1'b0;
            ba      <= '0;
            addr    <= '0;
            dqm     <= '0;
            dq_out  <= '0;
            dq_oe   <= 1'b0;
            ref_ack <= 1'b0;
        end else begin
            cmd     <= CMD_NOP;
            cke     <= 1'b1;
            dqm     <= '0;
            dq_oe   <= 1'b0;
            ref_ack <= 1'b0;
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                unique case (st)
                    ST_IPRE: begin
                        cmd  <= CMD_PRE;
                        addr <= ALL_BANKS;
                        st   <= ST_IREF1;
                        cnt  <= CNT_W'(T_RP - 1);
                    end
                    ST_IREF1: begin
                        cmd <= CMD_REF;
                        st  <= ST_IREF2;
                        cnt <= CNT_W'(T_RC - 1);
                    end
                    ST_IREF2: begin
                        cmd <= CMD_REF;
                        st  <= ST_IMRS;
                        cnt <= CNT_W'(T_RC - 1);
                    end
                    ST_IMRS: begin
                        cmd  <= CMD_MRS;
                        ba   <= '0;
                        addr <= mode_word(CAS_LAT);
                        st   <= ST_IDLE;
                        cnt  <= CNT_W'(T_MRD - 1);
                    end
                    ST_IDLE: begin
                        if (ref_req) begin
                            cmd     <= CMD_REF;
                            ref_ack <= 1'b1;
                            cnt     <= CNT_W'(T_RC - 1);
                        end else if (req_valid) begin
                            cur  <= split_req(req_write, req_addr, req_wdata, req_be);
                            cmd  <= CMD_ACT;
                            ba   <= req_addr[COL_W+BANK_W-1:COL_W];
                            addr <= req_addr[ADDR_W-1:COL_W+BANK_W];
                            st   <= ST_RW;
                            cnt  <= CNT_W'(T_RCD - 1);
                        end
                    end
                    ST_RW: begin
                        cmd  <= cur.wr ? CMD_WR : CMD_RD;
                        ba   <= cur.bank;
                        addr <= {{(ROW_W-COL_W){1'b0}}, cur.col};
                        if (cur.wr) begin
                            dq_oe  <= 1'b1;
                            dq_out <= cur.data;
                            dqm    <= ~cur.be;
                        end
                        st  <= ST_PRE;
                        cnt <= cur.wr ? CNT_W'(G_WR - 1) : CNT_W'(G_RD - 1);
                    end
                    ST_PRE: begin
                        cmd  <= CMD_PRE;
                        ba   <= cur.bank;
                        addr <= '0;
                        st   <= ST_IDLE;
                        cnt  <= cur.wr ? CNT_W'(GI_WR - 1) : CNT_W'(GI_RD - 1);
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    p_cke_up_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cke);

    p_cmd_then_nop_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

    p_lane_only_write_r6: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (cmd == CMD_WR));

    p_refresh_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> !req_ready);

    p_ack_with_ref_r9: assert property (@(posedge clk) disable iff (rst)
        ref_ack |-> (cmd == CMD_REF));

    p_accept_activates_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd == CMD_ACT));

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
    import sdram_seq_pkg::*;
#(
    parameter int CAS_LAT  = 2,
    parameter int T_RCD    = 2,
    parameter int T_RP     = 2,
    parameter int T_RAS    = 5,
    parameter int T_RC     = 7,
    parameter int T_WR     = 2,
    parameter int T_MRD    = 2,
    parameter int INIT_CYC = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [22:0] req_addr,
    input  logic [63:0] req_wdata,
    input  logic [7:0]  req_be,
    output logic        rd_valid,
    output logic [63:0] rd_data,
    input  logic        ref_req,
    output logic        ref_ack,
    output logic        sd_cke,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic [1:0]  sd_ba,
    output logic [11:0] sd_addr,
    output logic [7:0]  sd_dqm,
    output logic [63:0] sd_dq_out,
    output logic        sd_dq_oe,
    input  logic [63:0] sd_dq_in
);
    sd_cmd_e cmd;

    sdram_seq_fsm #(
        .CAS_LAT(CAS_LAT), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS),
        .T_RC(T_RC), .T_WR(T_WR), .T_MRD(T_MRD), .INIT_CYC(INIT_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .ref_req   (ref_req),
        .ref_ack   (ref_ack),
        .cke       (sd_cke),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr),
        .dqm       (sd_dqm),
        .dq_out    (sd_dq_out),
        .dq_oe     (sd_dq_oe)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdram_rd_capture #(
        .CAS_LAT(CAS_LAT)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rd_issued (cmd == CMD_RD),
        .dq_in     (sd_dq_in),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sdram_seq_ctrl_test.sv
`timescale 1ns/1ps
module sdram_seq_ctrl_test;
    import sdram_seq_pkg::*;

    localparam int CL = 2, TRCD = 2, TRP = 2, TRAS = 5, TRC = 7, TWR = 2, TMRD = 2, INIT = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 0, req_write = 0, ref_req = 0;
    logic [22:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        req_ready, rd_valid, ref_ack;
    logic [63:0] rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [7:0]  sd_dqm;
    logic [63:0] sd_dq_out;
    logic [63:0] sd_dq_in = '0;

    sdram_seq_ctrl #(.CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_RAS(TRAS), .T_RC(TRC),
                     .T_WR(TWR), .T_MRD(TMRD), .INIT_CYC(INIT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

    int n_cmp = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural device memory (pin level) and request-level reference memory
    logic [63:0] dev_mem [logic [22:0]];
    logic [63:0] ref_mem [logic [22:0]];
    logic [22:0] pend_q[$];
    logic [63:0] exp_q[$];

    function automatic logic [63:0] seedv(input logic [22:0] a);
        return {9'h0, a, 9'h0, a} ^ 64'h5A5A_0F0F_3C3C_9696;
    endfunction
    function automatic logic [63:0] dev_rd(input logic [22:0] a);
        return dev_mem.exists(a) ? dev_mem[a] : seedv(a);
    endfunction
    function automatic logic [63:0] ref_rd(input logic [22:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : seedv(a);
    endfunction

    // cycle-by-cycle monitor: protocol, gaps, data return
    int cyc = 0, c0 = -1;
    int last_act = -1000, last_pre = -1000, last_ref = -1000, last_mrs = -1000;
    int last_wr = -1000, last_rd = -1000, rd_cyc = -1000;
    int init_step = 0, n_ref = 0;
    bit init_done = 0, row_open = 0, ref_last = 0, drop_ref = 0;
    logic [1:0]  o_bank;
    logic [11:0] o_row;
    logic [63:0] rd_word;

    always @(negedge clk) begin
        sd_cmd_e c;
        logic [22:0] a;
        logic [63:0] w;
        bit exp_v;
        c = sd_cmd_e'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n});
        cyc++;
        if (!rst) begin
            if (c0 < 0) c0 = cyc;
            if (cyc > c0) check(sd_cke == 1'b1, "R1 clock enable high", sd_cke, 1);
            exp_v = (cyc == rd_cyc + CL + 1);
            check(rd_valid == exp_v, "R8 read valid timing", rd_valid, exp_v);
            if (rd_valid && exp_v) begin
                if (exp_q.size() == 0) check(0, "R8 unexpected read data", rd_data, 0);
                else check(rd_data == exp_q[0], "R8 read data", rd_data, exp_q[0]);
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            check(ref_ack == (c == CMD_REF && init_done), "R9 refresh acknowledge", ref_ack,
                  (c == CMD_REF && init_done));
            if (c != CMD_WR) begin
                check(sd_dq_oe == 1'b0, "R6 lane idle", sd_dq_oe, 0);
                check(sd_dqm == 8'h00, "R6 mask idle", sd_dqm, 0);
            end
            if (c != CMD_NOP) begin
                check(cyc - last_mrs >= TMRD, "R5 mode-set gap", 64'(cyc - last_mrs), TMRD);
                case (c)
                    CMD_ACT: begin
                        check(init_done, "R2 activate before mode set", init_done, 1);
                        check(!row_open, "R10 activate with row open", row_open, 0);
                        check(!ref_last, "R9 activate while refresh pending", ref_last, 0);
                        check(cyc - last_pre >= TRP, "R5 precharge-activate", 64'(cyc - last_pre), TRP);
                        check(cyc - last_act >= TRC, "R5 activate-activate", 64'(cyc - last_act), TRC);
                        check(cyc - last_ref >= TRC, "R5 refresh-activate", 64'(cyc - last_ref), TRC);
                        if (pend_q.size() == 0) check(0, "R10 activate with no request", 0, 1);
                        else check({sd_addr, sd_ba} == pend_q[0][22:9], "R4 row and bank",
                                   {sd_addr, sd_ba}, pend_q[0][22:9]);
                        row_open = 1; o_bank = sd_ba; o_row = sd_addr; last_act = cyc;
                    end
                    CMD_RD, CMD_WR: begin
                        check(row_open && sd_ba == o_bank, "R4 column bank", sd_ba, o_bank);
                        check(sd_addr[10] == 1'b0, "R4 auto-precharge bit low", sd_addr[10], 0);
                        check(cyc - last_act >= TRCD, "R5 activate-column", 64'(cyc - last_act), TRCD);
                        a = {o_row, o_bank, sd_addr[8:0]};
                        if (pend_q.size() == 0) check(0, "R4 column with no request", a, 0);
                        else begin
                            check(a == pend_q[0], "R4 full address", a, pend_q[0]);
                            void'(pend_q.pop_front());
                        end
                        if (c == CMD_WR) begin
                            check(sd_dq_oe == 1'b1, "R6 lane driven on write", sd_dq_oe, 1);
                            w = dev_rd(a);
                            for (int b = 0; b < 8; b++)
                                if (!sd_dqm[b]) w[8*b +: 8] = sd_dq_out[8*b +: 8];
                            dev_mem[a] = w;
                            last_wr = cyc;
                        end else begin
                            rd_cyc = cyc; rd_word = dev_rd(a); last_rd = cyc;
                        end
                    end
                    CMD_PRE: begin
                        if (sd_addr[10]) begin
                            if (init_step == 0) begin
                                check(cyc - c0 == INIT, "R2 power-up wait", 64'(cyc - c0), INIT);
                                init_step = 1;
                            end else check(0, "R2 stray precharge-all", init_step, 0);
                        end else begin
                            check(row_open && sd_ba == o_bank, "R4 precharge bank", sd_ba, o_bank);
                            check(sd_addr == 12'h000, "R4 precharge address", sd_addr, 0);
                        end
                        check(cyc - last_act >= TRAS, "R5 activate-precharge", 64'(cyc - last_act), TRAS);
                        check(cyc - last_wr >= TWR, "R7 write recovery", 64'(cyc - last_wr), TWR);
                        check(cyc - last_rd >= CL, "R8 read-precharge", 64'(cyc - last_rd), CL);
                        row_open = 0; last_pre = cyc;
                    end
                    CMD_REF: begin
                        check(!row_open, "R5 refresh with row open", row_open, 0);
                        check(cyc - last_pre >= TRP, "R5 precharge-refresh", 64'(cyc - last_pre), TRP);
                        check(cyc - last_ref >= TRC, "R5 refresh-refresh", 64'(cyc - last_ref), TRC);
                        check(cyc - last_act >= TRC, "R5 activate-refresh", 64'(cyc - last_act), TRC);
                        if (!init_done) begin
                            check(init_step == 1 || init_step == 2, "R2 refresh order", init_step, 1);
                            if (init_step == 1)
                                check(cyc - last_pre == TRP, "R2 first refresh spacing",
                                      64'(cyc - last_pre), TRP);
                            else
                                check(cyc - last_ref == TRC, "R2 second refresh spacing",
                                      64'(cyc - last_ref), TRC);
                            init_step++;
                        end else n_ref++;
                        last_ref = cyc;
                    end
                    CMD_MRS: begin
                        check(init_step == 3, "R2 mode set order", init_step, 3);
                        check(cyc - last_ref == TRC, "R2 mode set spacing", 64'(cyc - last_ref), TRC);
                        check(sd_addr == 12'(CL << 4) && sd_ba == 2'b00, "R2 mode word", sd_addr, 12'(CL << 4));
                        init_step = 4; init_done = 1; last_mrs = cyc;
                    end
                    default: check(0, "R3 illegal command code", c, CMD_NOP);
                endcase
            end
            if (ref_ack) drop_ref = 1;
            ref_last = ref_req;
            sd_dq_in = (cyc == rd_cyc + CL) ? rd_word : 64'hBAD0_BAD0_BAD0_BAD0 ^ 64'(cyc);
        end
    end

    always @(posedge clk) begin
        if (drop_ref) begin
            drop_ref = 0;
            #2 ref_req = 0;
        end
    end

    task automatic do_req(input bit w, input logic [22:0] a, input logic [63:0] d,
                          input logic [7:0] be, input bit with_ref);
        logic [63:0] m;
        @(posedge clk); #2;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        if (with_ref) ref_req = 1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        pend_q.push_back(a);
        if (w) begin
            m = ref_rd(a);
            for (int b = 0; b < 8; b++)
                if (be[b]) m[8*b +: 8] = d[8*b +: 8];
            ref_mem[a] = m;
        end else exp_q.push_back(ref_rd(a));
        @(posedge clk); #2;
        req_valid = 0;
        @(negedge clk);
        check(!req_ready, "R10 ready drops after accept", req_ready, 0);
    endtask

    task automatic wait_ready();
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
    endtask

    logic [22:0] A0, A1, A2, A3;

    initial begin
        A0 = 23'h00_1234;
        A1 = {12'hFFF, 2'b11, 9'h1FF};
        A2 = {12'h000, 2'b10, 9'h000};
        A3 = {12'h5A5, 2'b01, 9'h0AA};
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sd_cke == 1'b0, "R1 reset clock enable", sd_cke, 0);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset NOP",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        check(!req_ready && !rd_valid && !ref_ack && !sd_dq_oe, "R1 reset outputs",
              {req_ready, rd_valid, ref_ack, sd_dq_oe}, 0);
        @(posedge clk); #2 rst = 0;
        wait_ready();
        check(init_step == 4, "R2 init complete before ready", init_step, 4);

        do_req(1, A0, 64'h1122_3344_5566_7788, 8'hFF, 0);
        do_req(0, A0, '0, '0, 0);
        do_req(1, A0, 64'hAABB_CCDD_EEFF_0011, 8'h0F, 0);
        do_req(0, A0, '0, '0, 0);
        do_req(1, A1, 64'hDEAD_BEEF_CAFE_F00D, 8'hC3, 0);
        do_req(0, A1, '0, '0, 0);
        do_req(1, A2, 64'h0123_4567_89AB_CDEF, 8'h80, 0);
        do_req(0, A2, '0, '0, 0);
        do_req(0, A3, '0, '0, 0);

        // refresh on its own
        @(posedge clk); #2 ref_req = 1;
        while (ref_req) @(posedge clk);
        repeat (2) @(negedge clk);
        check(n_ref == 1, "R9 solo refresh issued", n_ref, 1);

        // refresh and request in the same cycle
        do_req(0, A1, '0, '0, 1);
        check(n_ref == 2, "R9 refresh served first", n_ref, 2);

        for (int i = 0; i < 6; i++) begin
            logic [22:0] a;
            a = {12'(i * 37 + 5), 2'(i), 9'(i * 61 + 3)};
            do_req(1, a, {8{8'(i * 17 + 1)}} ^ 64'hF0E1_D2C3_B4A5_9687, 8'(8'hFF >> i), 0);
            do_req(0, a, '0, '0, 0);
        end

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8 every read returned", exp_q.size(), 0);
        check(pend_q.size() == 0, "R10 every request served", pend_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule